// File: doc/BRIEF.md
# Indirect-Access Prioritized Vectored Interrupt Controller

This block gathers up to 128 interrupt lines and drives one IRQ request towards a processor. Each line has a 3-bit priority, a trigger type (high or low level, rising or falling edge), a data-width vector value and an enable bit. Software does not reach these settings through one register per line. It first writes a line number into a select register. The mode, vector, enable, disable, clear and set accesses then act on that line alone.

An arbiter picks the pending, enabled line with the highest priority. When priorities are equal, the lower line number wins. IRQ is raised when that line may preempt the interrupt now in service. Reading the active-vector register returns the winner's vector and acknowledges it. The acknowledge pushes the winner's priority and line number onto an 8-deep nesting stack and clears an edge-triggered line. While the stack holds an entry, only a strictly higher priority raises IRQ. Each end-of-interrupt write pops one entry, so eight such writes always return the block to idle.

Top module: `aic_vic_top`

## Requirements
- R1: After reset every line is disabled and not pending, and the nesting stack is empty. IRQ is low, the current-source register (0x18) reads 0, and the active-vector register (0x10) returns the spurious value, which resets to 0.
- R2: The select register (0x00) keeps bits [6:0] of a write. The mode register (0x04) and the vector register (0x08) read and write only the selected line. Mode keeps bits [2:0] (priority) and [6:5] (trigger) and reads the other bits as 0.
- R3: A write with bit 0 set to 0x40 enables the selected line, and one to 0x44 disables it. A write with bit 0 clear has no effect. Register 0x30 reads the selected line's enable in bit 0. A disabled line keeps its pending state.
- R4: A write with bit 0 set to 0x4C forces the selected line pending, and one to 0x48 clears its latched pending state. A write with bit 0 clear has no effect. An acknowledge also removes a forced pending.
- R5: The trigger field mode[6:5] selects how a line becomes pending: 00 while the input is high, 01 while it is low, 10 on a rising edge, 11 on a falling edge. A level line is pending only while its input is active.
- R6: Among pending, enabled lines the highest priority wins. On equal priority the lowest line number wins.
- R7: Reading 0x10 while IRQ is high returns the winner's vector and pushes the winner onto the stack. With IRQ low the read returns the spurious register (0x3C) and pushes nothing.
- R8: An acknowledge clears an edge line's latched edge, but a level line stays pending while its input is active. A new edge that arrives in the same cycle as the acknowledge is kept.
- R9: While the stack is not empty, IRQ is raised only for a winner whose priority is strictly above the stacked top. A write to 0x38 pops one entry. It has no effect on an empty stack.
- R10: Register 0x18 reads the line number on top of the stack, or 0 when the stack is empty.
- R11: The stack holds 8 levels and never overflows. Eight end-of-interrupt writes return any nesting state to empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt input lines |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; an active-vector read acknowledges at the clock edge |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the address |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two of the block's functions can act on one line in the same cycle: the acknowledge that clears a latched edge, and the detection of a fresh edge on that same line. The bench pulses an edge line so that it is already pending. It then drops and raises the input again, timed so that the second rising edge is being detected in exactly the cycle in which the active-vector read acknowledges the first. The design passes if, after the end-of-interrupt, IRQ is still high and a second active-vector read returns the same vector. After a further end-of-interrupt, IRQ must fall.

// File: rtl/aic_vic_pkg.sv
package aic_vic_pkg;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int PRIO_W = 3;
  localparam int MODE_W = 7;
  localparam logic [MODE_W-1:0] MODE_KEEP = 7'b110_0111;

  localparam logic [7:0] OFS_SEL   = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_VEC   = 8'h08;
  localparam logic [7:0] OFS_IVEC  = 8'h10;
  localparam logic [7:0] OFS_CUR   = 8'h18;
  localparam logic [7:0] OFS_MSTAT = 8'h30;
  localparam logic [7:0] OFS_EOI   = 8'h38;
  localparam logic [7:0] OFS_SPUR  = 8'h3C;
  localparam logic [7:0] OFS_EN    = 8'h40;
  localparam logic [7:0] OFS_DIS   = 8'h44;
  localparam logic [7:0] OFS_CLR   = 8'h48;
  localparam logic [7:0] OFS_SET   = 8'h4C;

  function automatic logic trig_is_edge(trig_e t);
    return (t == TRIG_RISE) || (t == TRIG_FALL);
  endfunction

  function automatic logic line_active(trig_e t, logic raw);
    return ((t == TRIG_LOW) || (t == TRIG_FALL)) ? ~raw : raw;
  endfunction

  function automatic logic may_preempt(logic [PRIO_W-1:0] cand,
                                       logic [PRIO_W-1:0] top,
                                       logic empty);
    return empty || (cand > top);
  endfunction

endpackage

// File: rtl/aic_src_bank.sv
module aic_src_bank
  import aic_vic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int SEL_W   = 7,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_in,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      cmd_en,
  input  logic                      cmd_dis,
  input  logic                      cmd_clr,
  input  logic                      cmd_set,
  input  logic                      mode_wr,
  input  logic [MODE_W-1:0]         mode_wdata,
  input  logic                      vec_wr,
  input  logic [DATA_W-1:0]         vec_wdata,
  input  logic                      ack,
  input  logic [SEL_W-1:0]          win_idx,
  output logic [NUM_SRC-1:0]        cand,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [MODE_W-1:0]         sel_mode,
  output logic [DATA_W-1:0]         sel_vec,
  output logic                      sel_en,
  output logic [DATA_W-1:0]         win_vec
);

  logic [NUM_SRC-1:0] en_q, force_q, edge_q, in_q, prev_q;
  logic [NUM_SRC-1:0] edge_now, pend, sel_hit, ack_hit;
  logic [MODE_W-1:0]  mode_q [NUM_SRC];
  logic [DATA_W-1:0]  vec_q  [NUM_SRC];
  logic               sel_ok;

  assign sel_ok = (int'(sel) < NUM_SRC);

  // per-line trigger decoding and candidate forming
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    trig_e trig;
    logic  act_now, act_prev;
    assign trig        = trig_e'(mode_q[i][6:5]);
    assign act_now     = line_active(trig, in_q[i]);
    assign act_prev    = line_active(trig, prev_q[i]);
    assign edge_now[i] = trig_is_edge(trig) & act_now & ~act_prev;
    assign pend[i]     = force_q[i] | (trig_is_edge(trig) ? edge_q[i] : act_now);
    assign cand[i]     = en_q[i] & pend[i];
    assign sel_hit[i]  = sel_ok && (sel == SEL_W'(i));
    assign ack_hit[i]  = ack && (win_idx == SEL_W'(i));
    assign prio_flat[i*PRIO_W +: PRIO_W] = mode_q[i][PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      prev_q  <= '0;
      en_q    <= '0;
      force_q <= '0;
      edge_q  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end
    end else begin
      in_q   <= src_in;
      prev_q <= in_q;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (sel_hit[i] && cmd_en)
          en_q[i] <= 1'b1;
        else if (sel_hit[i] && cmd_dis)
          en_q[i] <= 1'b0;
        // a fresh edge outranks a clear or an acknowledge in the same cycle
        edge_q[i]  <= edge_now[i] |
                      (edge_q[i] & ~(sel_hit[i] & cmd_clr) & ~ack_hit[i]);
        force_q[i] <= (sel_hit[i] & cmd_set) |
                      (force_q[i] & ~(sel_hit[i] & cmd_clr) & ~ack_hit[i]);
        if (sel_hit[i] && mode_wr)
          mode_q[i] <= mode_wdata & MODE_KEEP;
        if (sel_hit[i] && vec_wr)
          vec_q[i] <= vec_wdata;
      end
    end
  end

  assign sel_mode = sel_ok ? mode_q[sel] : '0;
  assign sel_vec  = sel_ok ? vec_q[sel]  : '0;
  assign sel_en   = sel_ok & en_q[sel];
  assign win_vec  = vec_q[win_idx];

endmodule

// File: rtl/aic_arbiter.sv
module aic_arbiter
  import aic_vic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int SEL_W   = 7
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      any,
  output logic [SEL_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);

  // ascending scan; strict compare keeps the lowest index on a tie
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!any || (prio_flat[i*PRIO_W +: PRIO_W] > win_prio))) begin
        any      = 1'b1;
        win_idx  = SEL_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/aic_nest_stack.sv
module aic_nest_stack
  import aic_vic_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEL_W = 7,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [SEL_W-1:0]  push_src,
  input  logic              pop,
  output logic [CNT_W-1:0]  depth,
  output logic              empty,
  output logic              full,
  output logic [PRIO_W-1:0] top_prio,
  output logic [SEL_W-1:0]  top_src
);

  logic [PRIO_W-1:0] prio_stk [DEPTH];
  logic [SEL_W-1:0]  src_stk  [DEPTH];
  logic [IDX_W-1:0]  top_idx;

  assign empty   = (depth == '0);
  assign full    = (depth == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(depth - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_stk[i] <= '0;
        src_stk[i]  <= '0;
      end
    end else if (push && !full) begin
      prio_stk[IDX_W'(depth)] <= push_prio;
      src_stk[IDX_W'(depth)]  <= push_src;
      depth <= depth + 1'b1;
    end else if (pop && !empty) begin
      depth <= depth - 1'b1;
    end
  end

  assign top_prio = empty ? '0 : prio_stk[top_idx];
  assign top_src  = empty ? '0 : src_stk[top_idx];

endmodule

// File: rtl/aic_vic_top.sv
module aic_vic_top
  import aic_vic_pkg::*;
#(
  parameter int NUM_SRC    = 128,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NEST_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);

  localparam int SEL_W = $clog2(NUM_SRC);
  localparam int CNT_W = $clog2(NEST_DEPTH + 1);
  localparam int IDX_W = $clog2(NEST_DEPTH);

  function automatic logic at(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // named bus events
  logic wr_sel, wr_mode, wr_vec, wr_spur, eoi_wr;
  logic cmd_en, cmd_dis, cmd_clr, cmd_set, ivec_rd, push_req;

  assign wr_sel  = bus_wr && at(bus_addr, OFS_SEL);
  assign wr_mode = bus_wr && at(bus_addr, OFS_MODE);
  assign wr_vec  = bus_wr && at(bus_addr, OFS_VEC);
  assign wr_spur = bus_wr && at(bus_addr, OFS_SPUR);
  assign eoi_wr  = bus_wr && at(bus_addr, OFS_EOI);
  assign cmd_en  = bus_wr && at(bus_addr, OFS_EN)  && bus_wdata[0];
  assign cmd_dis = bus_wr && at(bus_addr, OFS_DIS) && bus_wdata[0];
  assign cmd_clr = bus_wr && at(bus_addr, OFS_CLR) && bus_wdata[0];
  assign cmd_set = bus_wr && at(bus_addr, OFS_SET) && bus_wdata[0];
  assign ivec_rd = bus_rd && at(bus_addr, OFS_IVEC);

  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] spur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      spur_q <= '0;
    end else begin
      if (wr_sel)  sel_q  <= bus_wdata[SEL_W-1:0];
      if (wr_spur) spur_q <= bus_wdata;
    end
  end

  logic [NUM_SRC-1:0]        cand;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [MODE_W-1:0]         sel_mode;
  logic [DATA_W-1:0]         sel_vec, win_vec;
  logic                      sel_en, arb_any;
  logic [SEL_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio, top_prio;
  logic [SEL_W-1:0]          top_src;
  logic [CNT_W-1:0]          stk_depth;
  logic                      stk_empty, stk_full;

  aic_src_bank #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .sel        (sel_q),
    .cmd_en     (cmd_en),
    .cmd_dis    (cmd_dis),
    .cmd_clr    (cmd_clr),
    .cmd_set    (cmd_set),
    .mode_wr    (wr_mode),
    .mode_wdata (bus_wdata[MODE_W-1:0]),
    .vec_wr     (wr_vec),
    .vec_wdata  (bus_wdata),
    .ack        (push_req),
    .win_idx    (win_idx),
    .cand       (cand),
    .prio_flat  (prio_flat),
    .sel_mode   (sel_mode),
    .sel_vec    (sel_vec),
    .sel_en     (sel_en),
    .win_vec    (win_vec)
  );

  aic_arbiter #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_arb (
    .cand      (cand),
    .prio_flat (prio_flat),
    .any       (arb_any),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  aic_nest_stack #(.DEPTH(NEST_DEPTH), .SEL_W(SEL_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_req),
    .push_prio (win_prio),
    .push_src  (win_idx),
    .pop       (eoi_wr),
    .depth     (stk_depth),
    .empty     (stk_empty),
    .full      (stk_full),
    .top_prio  (top_prio),
    .top_src   (top_src)
  );

  assign irq_o    = arb_any && may_preempt(win_prio, top_prio, stk_empty);
  assign push_req = ivec_rd && irq_o;

  logic [DATA_W-1:0] cur_src_val;
  assign cur_src_val = stk_empty ? '0 : DATA_W'(top_src);

  always_comb begin
    bus_rdata = '0;
    if (at(bus_addr, OFS_SEL))        bus_rdata = DATA_W'(sel_q);
    else if (at(bus_addr, OFS_MODE))  bus_rdata = DATA_W'(sel_mode);
    else if (at(bus_addr, OFS_VEC))   bus_rdata = sel_vec;
    else if (at(bus_addr, OFS_IVEC))  bus_rdata = irq_o ? win_vec : spur_q;
    else if (at(bus_addr, OFS_CUR))   bus_rdata = cur_src_val;
    else if (at(bus_addr, OFS_MSTAT)) bus_rdata = DATA_W'(sel_en);
    else if (at(bus_addr, OFS_SPUR))  bus_rdata = spur_q;
  end

endmodule

// File: rtl/aic_vic_checks.sv
module aic_vic_checks
  import aic_vic_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 32,
  parameter int NEST_DEPTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              arb_any,
  input logic              push_req,
  input logic              eoi_wr,
  input logic              stk_empty,
  input logic              stk_full,
  input logic [CNT_W-1:0]  stk_depth,
  input logic [PRIO_W-1:0] win_prio,
  input logic [PRIO_W-1:0] top_prio,
  input logic [DATA_W-1:0] cur_src_val
);

  assert_irq_has_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> arb_any);

  assert_preempt_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stk_empty) |-> (win_prio > top_prio));

  assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> (stk_depth == $past(stk_depth) + 1'b1));

  assert_eoi_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !stk_empty) |=> (stk_depth == $past(stk_depth) - 1'b1));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> !stk_full);

  assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= CNT_W'(NEST_DEPTH));

  assert_idle_cur_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_empty |-> (cur_src_val == '0));

endmodule

bind aic_vic_top aic_vic_checks #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NEST_DEPTH(NEST_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .arb_any     (arb_any),
  .push_req    (push_req),
  .eoi_wr      (eoi_wr),
  .stk_empty   (stk_empty),
  .stk_full    (stk_full),
  .stk_depth   (stk_depth),
  .win_prio    (win_prio),
  .top_prio    (top_prio),
  .cur_src_val (cur_src_val)
);

// File: tb/tb_aic_vic_top.sv
module tb_aic_vic_top;

  localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08, A_IVEC = 8'h10;
  localparam logic [7:0] A_CUR = 8'h18, A_MST = 8'h30, A_EOI = 8'h38, A_SPUR = 8'h3C;
  localparam logic [7:0] A_EN = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48, A_SET = 8'h4C;
  localparam logic [1:0] T_HI = 2'b00, T_LO = 2'b01, T_RISE = 2'b10, T_FALL = 2'b11;
  localparam logic [31:0] SPUR = 32'hDEAD_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_in = '0;
  logic [7:0]   addr = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;

  always #5 clk = ~clk;

  aic_vic_top dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq_o(irq)
  );

  // scoreboard
  string       exp_tag[$];
  logic [31:0] exp_val[$];
  logic [31:0] act_val[$];
  int          n_run = 0, n_fail = 0;
  logic [31:0] m_a, m_e;
  string       m_t;
  bit          done = 1'b0;

  initial forever begin
    @(posedge clk);
    while (act_val.size() > 0 && exp_val.size() > 0) begin
      m_a = act_val.pop_front();
      m_e = exp_val.pop_front();
      m_t = exp_tag.pop_front();
      n_run++;
      if (m_a !== m_e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", m_t, m_a, m_e);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    #1;
    exp_tag.push_back(tag); exp_val.push_back(e); act_val.push_back(rdata);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    @(negedge clk); #1;
    exp_tag.push_back(tag); exp_val.push_back({31'b0, e}); act_val.push_back({31'b0, irq});
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src_in[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int s, input logic [1:0] t, input logic [2:0] p, input logic [31:0] v);
    wr_reg(A_SEL, s);
    wr_reg(A_MODE, {25'b0, t, 2'b00, p});
    wr_reg(A_VEC, v);
    wr_reg(A_EN, 32'h1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    irq_chk(1'b0, "R1 irq idle");
    rd_chk(A_CUR, 0, "R1 cur zero");
    rd_chk(A_IVEC, 0, "R1 spurious reset");
    rd_chk(A_MST, 0, "R1 line 0 disabled");
    rd_chk(A_MODE, 0, "R1 mode zero");
    wr_reg(A_SPUR, SPUR);
    rd_chk(A_IVEC, SPUR, "R7 spurious value");

    // R2 indirect access
    wr_reg(A_SEL, 5);
    wr_reg(A_MODE, 32'hFF);
    wr_reg(A_VEC, 32'h1000_0005);
    rd_chk(A_MODE, 32'h67, "R2 mode masked");
    rd_chk(A_VEC, 32'h1000_0005, "R2 vec readback");
    wr_reg(A_SEL, 6);
    rd_chk(A_VEC, 0, "R2 other line vec");
    rd_chk(A_MODE, 0, "R2 other line mode");
    rd_chk(A_SEL, 6, "R2 sel readback");
    wr_reg(A_SEL, 32'h1FF);
    rd_chk(A_SEL, 32'h7F, "R2 sel bits 6:0");

    // R3 enable / disable
    wr_reg(A_SEL, 3);
    wr_reg(A_EN, 0);
    rd_chk(A_MST, 0, "R3 enable bit0 clear ignored");
    wr_reg(A_EN, 1);
    rd_chk(A_MST, 1, "R3 enabled");
    wr_reg(A_DIS, 0);
    rd_chk(A_MST, 1, "R3 disable bit0 clear ignored");
    wr_reg(A_DIS, 1);
    rd_chk(A_MST, 0, "R3 disabled");

    // R5 level lines
    cfg(3, T_HI, 3'd2, 32'h33);
    set_src(3, 1'b1);
    irq_chk(1'b1, "R5 high level pending");
    set_src(3, 1'b0);
    irq_chk(1'b0, "R5 high level drops");
    cfg(4, T_LO, 3'd1, 32'h44);
    irq_chk(1'b1, "R5 low level pending");
    set_src(4, 1'b1);
    irq_chk(1'b0, "R5 low level inactive");

    // R6 / R7 / R9 / R10 arbitration and nesting
    cfg(9, T_HI, 3'd2, 32'h99);
    cfg(10, T_HI, 3'd5, 32'hAA);
    set_src(9, 1'b1);
    set_src(3, 1'b1);
    rd_chk(A_IVEC, 32'h33, "R6 tie lowest index");
    rd_chk(A_CUR, 3, "R10 cur after ack");
    wr_reg(A_EOI, 0);
    rd_chk(A_CUR, 0, "R10 cur after eoi");
    set_src(10, 1'b1);
    rd_chk(A_IVEC, 32'hAA, "R6 higher priority wins");
    rd_chk(A_CUR, 10, "R10 cur line 10");
    irq_chk(1'b0, "R9 lower priority held off");
    wr_reg(A_EOI, 0);
    irq_chk(1'b1, "R9 released after eoi");
    set_src(3, 1'b0); set_src(9, 1'b0); set_src(10, 1'b0);
    irq_chk(1'b0, "R5 all levels dropped");

    // R8 edge versus level acknowledge
    cfg(5, T_RISE, 3'd7, 32'h1000_0005);
    set_src(5, 1'b1); idle(1);
    irq_chk(1'b1, "R5 rising edge pending");
    rd_chk(A_IVEC, 32'h1000_0005, "R7 edge vector");
    rd_chk(A_CUR, 5, "R10 cur line 5");
    wr_reg(A_EOI, 0);
    irq_chk(1'b0, "R8 edge cleared by ack");
    set_src(3, 1'b1);
    rd_chk(A_IVEC, 32'h33, "R7 level vector");
    wr_reg(A_EOI, 0);
    irq_chk(1'b1, "R8 level stays pending");
    set_src(3, 1'b0);
    irq_chk(1'b0, "R8 level released");

    cfg(11, T_FALL, 3'd3, 32'hB);
    set_src(11, 1'b1); idle(1);
    irq_chk(1'b0, "R5 falling ignores rise");
    set_src(11, 1'b0); idle(1);
    irq_chk(1'b1, "R5 falling edge pending");
    rd_chk(A_IVEC, 32'hB, "R7 falling vector");
    wr_reg(A_EOI, 0);
    irq_chk(1'b0, "R8 falling cleared");

    // R4 set / clear, R3 pending kept while disabled
    wr_reg(A_SET, 0);
    irq_chk(1'b0, "R4 set bit0 clear ignored");
    wr_reg(A_SET, 1);
    irq_chk(1'b1, "R4 set forces pending");
    wr_reg(A_CLR, 0);
    irq_chk(1'b1, "R4 clear bit0 clear ignored");
    wr_reg(A_CLR, 1);
    irq_chk(1'b0, "R4 clear removes pending");
    wr_reg(A_DIS, 1);
    wr_reg(A_SET, 1);
    irq_chk(1'b0, "R3 disabled line silent");
    wr_reg(A_EN, 1);
    irq_chk(1'b1, "R3 pending kept while disabled");
    rd_chk(A_IVEC, 32'hB, "R4 forced vector");
    wr_reg(A_EOI, 0);
    irq_chk(1'b0, "R4 ack removes forced");

    // R8 fresh edge in the acknowledge cycle
    set_src(5, 1'b0); set_src(5, 1'b1); idle(1);
    set_src(5, 1'b0); set_src(5, 1'b1);
    rd_chk(A_IVEC, 32'h1000_0005, "R8 ack during new edge");
    wr_reg(A_EOI, 0);
    irq_chk(1'b1, "R8 new edge kept");
    rd_chk(A_IVEC, 32'h1000_0005, "R8 second ack");
    wr_reg(A_EOI, 0);
    irq_chk(1'b0, "R8 edge finally cleared");

    // R9 / R11 full nesting depth
    for (int k = 0; k < 8; k++) cfg(20 + k, T_HI, 3'(k), 32'h200 + k);
    for (int k = 0; k < 8; k++) begin
      set_src(20 + k, 1'b1);
      irq_chk(1'b1, "R9 strictly higher preempts");
      rd_chk(A_IVEC, 32'h200 + k, "R11 nested vector");
    end
    rd_chk(A_CUR, 27, "R11 cur at full depth");
    irq_chk(1'b0, "R9 nothing above top");
    rd_chk(A_IVEC, SPUR, "R7 spurious while blocked");
    for (int j = 1; j <= 8; j++) begin
      wr_reg(A_EOI, 0);
      rd_chk(A_CUR, (j < 8) ? (27 - j) : 0, "R11 unwind cur");
      irq_chk(1'b1, "R9 pending above new top");
    end
    wr_reg(A_EOI, 0);
    rd_chk(A_CUR, 0, "R9 eoi on empty harmless");
    rd_chk(A_IVEC, 32'h207, "R6 top priority after unwind");
    wr_reg(A_EOI, 0);
    for (int k = 0; k < 8; k++) set_src(20 + k, 1'b0);
    irq_chk(1'b0, "R11 back to idle");

    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule